// File: doc/BRIEF.md
# Region-Partitioned Data Translation Buffer

This block translates data virtual page numbers to physical page numbers through three fully associative banks instead of one shared array. A classifier compares each page number with two programmable windows, one for the stack and one for global data. Everything outside both windows goes to the heap bank. Every lookup touches exactly one bank. Each bank keeps its own entries and its own replacement tree, so a burst of heap misses cannot push out stack or global translations. The banks hold 2, 8 and 32 entries by default.

The main port accepts a request with a page number and a store flag. A hit answers one cycle later. A miss holds the request information on the refill outputs and keeps `busy` high. The walker outside the block answers with `refillValid`, and the answer is written into the bank that missed and returned as the completion response. A second, stack-only probe port can serve a stack reference in the same cycle as the main port. A flush clears all three banks in one cycle.

Top module: `rdtlb`

## Requirements
- R1: The class of a page number is stack when stackLo <= vpn <= stackHi, otherwise global when globalLo <= vpn <= globalHi, otherwise heap. The class is reported on `refillBank` with the codes 0 stack, 1 global and 2 heap.
- R2: An accepted main-port request that hits gives `resp0Valid` high with the stored physical page on `resp0Ppn` on the next cycle, for one cycle.
- R3: An accepted request that misses gives no response. From the next cycle `busy` is high and `refillVpn`, `refillBank` and `refillWrite` show the request, and these hold until `refillValid` is seen.
- R4: When `refillValid` is high while `busy` is high, `refillPpn` is written into the pending bank. On the next cycle `resp0Valid` is high with that page and `busy` is low.
- R5: While `busy` is high, `req0Ready` is low for a request to the pending bank, for a request that would miss, and in the cycle of `refillValid`. A request that hits in another bank is still accepted and answered as in R2.
- R6: The probe port only looks up stack-class page numbers. For such a request, `resp1Valid` rises on the next cycle with `resp1Hit` and `resp1Ppn`, even when the main port hits the stack bank in the same cycle. For a request of another class, `resp1Valid` stays low.
- R7: A refill writes only into the bank of its class. Any number of heap refills leaves stack and global translations in place.
- R8: A refill takes the lowest-numbered invalid entry of its bank. If there is none, it takes the entry chosen by a binary tree of pseudo-LRU bits, updated on every hit and fill and cleared by flush. In the 2-entry stack bank the less recently used entry is replaced. After eight fills into an empty global bank and a hit on the first one, the next global miss replaces the fifth one filled.
- R9: A one-cycle `flush` invalidates every entry of all three banks, and later lookups of the old pages miss.
- R10: When `flush` and `refillValid` fall in the same cycle, the refilled translation stays valid after the flush.
- R11: After reset `busy`, `resp0Valid` and `resp1Valid` are low and `req0Ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all banks |
| stackLo | input | VPN_W | Lowest stack page |
| stackHi | input | VPN_W | Highest stack page |
| globalLo | input | VPN_W | Lowest global page |
| globalHi | input | VPN_W | Highest global page |
| req0Valid | input | 1 | Main lookup request |
| req0Vpn | input | VPN_W | Main lookup page number |
| req0Write | input | 1 | Main request is a store |
| req0Ready | output | 1 | Main request accepted this cycle |
| resp0Valid | output | 1 | Main response (hit or refill completion) |
| resp0Ppn | output | PPN_W | Main response physical page |
| req1Valid | input | 1 | Stack probe request |
| req1Vpn | input | VPN_W | Stack probe page number |
| resp1Valid | output | 1 | Probe response |
| resp1Hit | output | 1 | Probe found a translation |
| resp1Ppn | output | PPN_W | Probe physical page |
| busy | output | 1 | Miss pending, refill requested |
| refillVpn | output | VPN_W | Page number of the pending miss |
| refillBank | output | 2 | Class of the pending miss |
| refillWrite | output | 1 | Pending miss came from a store |
| refillValid | input | 1 | Refill data present |
| refillPpn | input | PPN_W | Refill physical page |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a refill completes while a flush arrives. The bench drives `refillValid` and `flush` on the same edge, expects the completion response, then expects a hit on the refilled page and misses on pages that were present before. In the second, the main port and the probe port both look up the stack bank in one cycle, and both responses must appear on the next cycle with the correct pages. The stall rules of R5 are also tested while a miss is pending: the bench offers a hit in another bank, a request to the same bank, a new miss, and a request in the refill cycle, and expects each one to be accepted or refused as R5 says.

// File: rtl/rdtlb_pkg.sv
package rdtlb_pkg;
  typedef enum logic [1:0] {
    BANK_STACK  = 2'd0,
    BANK_GLOBAL = 2'd1,
    BANK_HEAP   = 2'd2
  } bank_e;

  typedef struct packed {
    logic  hitAccept;
    logic  missStart;
    logic  fillNow;
    bank_e pendBank;
  } strobe_t;
endpackage

// File: rtl/rdtlb_bank.sv
module rdtlb_bank #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PORTS   = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic [PORTS-1:0][VPN_W-1:0]  lkVpn,
  input  logic [PORTS-1:0]             lkTouch,
  output logic [PORTS-1:0]             lkHit,
  output logic [PORTS-1:0][PPN_W-1:0]  lkPpn,
  input  logic                         fillEn,
  input  logic [VPN_W-1:0]             fillVpn,
  input  logic [PPN_W-1:0]             fillPpn
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NODES = ENTRIES - 1;

  logic [ENTRIES-1:0]            validQ;
  logic [ENTRIES-1:0][VPN_W-1:0] vpnQ;
  logic [ENTRIES-1:0][PPN_W-1:0] ppnQ;
  logic [NODES-1:0]              treeQ, treeD;
  logic [PORTS-1:0][IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]              freeIdx, victim;
  logic                          anyFree;

  function automatic logic [IDX_W-1:0] pickVictim(input logic [NODES-1:0] t);
    int node;
    node = 0;
    for (int l = 0; l < IDX_W; l++) node = 2 * node + 1 + int'(t[node]);
    return IDX_W'(node - NODES);
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [IDX_W-1:0] idx);
    int   node;
    logic dir;
    node = 0;
    for (int l = 0; l < IDX_W; l++) begin
      dir     = idx[IDX_W-1-l];
      t[node] = ~dir;
      node    = 2 * node + 1 + int'(dir);
    end
    return t;
  endfunction

  for (genvar p = 0; p < PORTS; p++) begin : gPort
    logic [ENTRIES-1:0] m;
    logic [IDX_W-1:0]   idx;
    logic [PPN_W-1:0]   pp;
    always_comb begin
      idx = '0;
      pp  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        m[e] = validQ[e] && (vpnQ[e] == lkVpn[p]);
        if (m[e]) begin
          idx = IDX_W'(e);
          pp  = pp | ppnQ[e];
        end
      end
    end
    assign lkHit[p]  = |m;
    assign lkPpn[p]  = pp;
    assign hitIdx[p] = idx;

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(m));
  end

  always_comb begin
    anyFree = ~&validQ;
    freeIdx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) if (!validQ[e]) freeIdx = IDX_W'(e);
    victim = anyFree ? freeIdx : pickVictim(treeQ);
  end

  always_comb begin
    logic [NODES-1:0] t;
    t = flush ? '0 : treeQ;
    if (!flush)
      for (int p = 0; p < PORTS; p++)
        if (lkTouch[p] && lkHit[p]) t = touch(t, hitIdx[p]);
    if (fillEn) t = touch(t, victim);
    treeD = t;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      treeQ  <= '0;
    end else begin
      treeQ <= treeD;
      if (flush) validQ <= '0;
      if (fillEn) validQ[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      vpnQ[victim] <= fillVpn;
      ppnQ[victim] <= fillPpn;
    end
  end

  // R8
  free_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && anyFree) |-> !validQ[victim]);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !fillEn) |=> (validQ == '0));
endmodule

// File: rtl/rdtlb_ctrl.sv
module rdtlb_ctrl
  import rdtlb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    req0Valid,
  input  bank_e   req0Bank,
  input  logic    req0Hit,
  input  logic    refillValid,
  output logic    req0Ready,
  output logic    busy,
  output strobe_t st
);
  logic  busyQ;
  bank_e pendQ;
  logic  accept;

  always_comb begin
    req0Ready    = !busyQ || (!refillValid && (req0Bank != pendQ) && req0Hit);
    accept       = req0Valid && req0Ready;
    st.hitAccept = accept && req0Hit;
    st.missStart = accept && !req0Hit;
    st.fillNow   = busyQ && refillValid;
    st.pendBank  = pendQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      pendQ <= BANK_HEAP;
    end else if (st.missStart) begin
      busyQ <= 1'b1;
      pendQ <= req0Bank;
    end else if (st.fillNow) begin
      busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !refillValid) |=> busyQ);

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(refillValid));

  // R5
  same_bank_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && req0Valid && (req0Bank == pendQ)) |-> !(st.hitAccept || st.missStart));
endmodule

// File: rtl/rdtlb_datapath.sv
module rdtlb_datapath
  import rdtlb_pkg::*;
#(
  parameter int STACK_N  = 2,
  parameter int GLOBAL_N = 8,
  parameter int HEAP_N   = 32,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [VPN_W-1:0] stackLo,
  input  logic [VPN_W-1:0] stackHi,
  input  logic [VPN_W-1:0] globalLo,
  input  logic [VPN_W-1:0] globalHi,
  input  logic [VPN_W-1:0] req0Vpn,
  input  logic             req0Write,
  input  logic             req1Valid,
  input  logic [VPN_W-1:0] req1Vpn,
  input  logic [PPN_W-1:0] refillPpn,
  input  strobe_t          st,
  output bank_e            req0Bank,
  output logic             req0Hit,
  output logic             resp0Valid,
  output logic [PPN_W-1:0] resp0Ppn,
  output logic             resp1Valid,
  output logic             resp1Hit,
  output logic [PPN_W-1:0] resp1Ppn,
  output logic [VPN_W-1:0] refillVpn,
  output logic [1:0]       refillBank,
  output logic             refillWrite
);
  function automatic bank_e classify(input logic [VPN_W-1:0] v);
    if (v >= stackLo && v <= stackHi)        return BANK_STACK;
    else if (v >= globalLo && v <= globalHi) return BANK_GLOBAL;
    else                                     return BANK_HEAP;
  endfunction

  logic                  req1Stack;
  logic [1:0]            stackHit;
  logic [1:0][PPN_W-1:0] stackPpn;
  logic                  globalHit, heapHit;
  logic [PPN_W-1:0]      globalPpn, heapPpn, selPpn;

  assign req0Bank  = classify(req0Vpn);
  assign req1Stack = (classify(req1Vpn) == BANK_STACK);

  rdtlb_bank #(.ENTRIES(STACK_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .PORTS(2)) uStack (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lkVpn({req1Vpn, req0Vpn}),
    .lkTouch({req1Valid && req1Stack, st.hitAccept && (req0Bank == BANK_STACK)}),
    .lkHit(stackHit), .lkPpn(stackPpn),
    .fillEn(st.fillNow && (st.pendBank == BANK_STACK)),
    .fillVpn(refillVpn), .fillPpn(refillPpn));

  rdtlb_bank #(.ENTRIES(GLOBAL_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .PORTS(1)) uGlobal (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lkVpn(req0Vpn),
    .lkTouch(st.hitAccept && (req0Bank == BANK_GLOBAL)),
    .lkHit(globalHit), .lkPpn(globalPpn),
    .fillEn(st.fillNow && (st.pendBank == BANK_GLOBAL)),
    .fillVpn(refillVpn), .fillPpn(refillPpn));

  rdtlb_bank #(.ENTRIES(HEAP_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .PORTS(1)) uHeap (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lkVpn(req0Vpn),
    .lkTouch(st.hitAccept && (req0Bank == BANK_HEAP)),
    .lkHit(heapHit), .lkPpn(heapPpn),
    .fillEn(st.fillNow && (st.pendBank == BANK_HEAP)),
    .fillVpn(refillVpn), .fillPpn(refillPpn));

  always_comb begin
    case (req0Bank)
      BANK_STACK:  begin req0Hit = stackHit[0]; selPpn = stackPpn[0]; end
      BANK_GLOBAL: begin req0Hit = globalHit;   selPpn = globalPpn;   end
      default:     begin req0Hit = heapHit;     selPpn = heapPpn;     end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resp0Valid  <= 1'b0;
      resp0Ppn    <= '0;
      resp1Valid  <= 1'b0;
      resp1Hit    <= 1'b0;
      resp1Ppn    <= '0;
      refillVpn   <= '0;
      refillBank  <= '0;
      refillWrite <= 1'b0;
    end else begin
      resp0Valid <= st.hitAccept || st.fillNow;
      if (st.fillNow)        resp0Ppn <= refillPpn;
      else if (st.hitAccept) resp0Ppn <= selPpn;
      resp1Valid <= req1Valid && req1Stack;
      resp1Hit   <= stackHit[1];
      resp1Ppn   <= stackPpn[1];
      if (st.missStart) begin
        refillVpn   <= req0Vpn;
        refillBank  <= req0Bank;
        refillWrite <= req0Write;
      end
    end
  end

  // R6
  probe_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    resp1Valid |-> $past(req1Valid && req1Stack));
endmodule

// File: rtl/rdtlb.sv
module rdtlb
  import rdtlb_pkg::*;
#(
  parameter int STACK_N  = 2,
  parameter int GLOBAL_N = 8,
  parameter int HEAP_N   = 32,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [VPN_W-1:0] stackLo,
  input  logic [VPN_W-1:0] stackHi,
  input  logic [VPN_W-1:0] globalLo,
  input  logic [VPN_W-1:0] globalHi,
  input  logic             req0Valid,
  input  logic [VPN_W-1:0] req0Vpn,
  input  logic             req0Write,
  output logic             req0Ready,
  output logic             resp0Valid,
  output logic [PPN_W-1:0] resp0Ppn,
  input  logic             req1Valid,
  input  logic [VPN_W-1:0] req1Vpn,
  output logic             resp1Valid,
  output logic             resp1Hit,
  output logic [PPN_W-1:0] resp1Ppn,
  output logic             busy,
  output logic [VPN_W-1:0] refillVpn,
  output logic [1:0]       refillBank,
  output logic             refillWrite,
  input  logic             refillValid,
  input  logic [PPN_W-1:0] refillPpn
);
  strobe_t st;
  bank_e   req0Bank;
  logic    req0Hit;

  rdtlb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .req0Valid(req0Valid), .req0Bank(req0Bank),
    .req0Hit(req0Hit), .refillValid(refillValid), .req0Ready(req0Ready),
    .busy(busy), .st(st));

  rdtlb_datapath #(.STACK_N(STACK_N), .GLOBAL_N(GLOBAL_N), .HEAP_N(HEAP_N),
                   .VPN_W(VPN_W), .PPN_W(PPN_W)) uDp (
    .clk(clk), .rstN(rstN), .flush(flush),
    .stackLo(stackLo), .stackHi(stackHi), .globalLo(globalLo), .globalHi(globalHi),
    .req0Vpn(req0Vpn), .req0Write(req0Write), .req1Valid(req1Valid), .req1Vpn(req1Vpn),
    .refillPpn(refillPpn), .st(st), .req0Bank(req0Bank), .req0Hit(req0Hit),
    .resp0Valid(resp0Valid), .resp0Ppn(resp0Ppn), .resp1Valid(resp1Valid),
    .resp1Hit(resp1Hit), .resp1Ppn(resp1Ppn), .refillVpn(refillVpn),
    .refillBank(refillBank), .refillWrite(refillWrite));
endmodule

// File: tb/tb_rdtlb.sv
module tb_rdtlb;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam logic [VW-1:0] SB = 20'hFFF00, SH = 20'hFFFFF;
  localparam logic [VW-1:0] GB = 20'h10000, GH = 20'h100FF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, flush, req0Valid, req0Write, req0Ready, resp0Valid;
  logic req1Valid, resp1Valid, resp1Hit, busy, refillWrite, refillValid;
  logic [VW-1:0] req0Vpn, req1Vpn, refillVpn;
  logic [PW-1:0] resp0Ppn, resp1Ppn, refillPpn;
  logic [1:0] refillBank;

  rdtlb dut (
    .clk(clk), .rstN(rstN), .flush(flush), .stackLo(SB), .stackHi(SH),
    .globalLo(GB), .globalHi(GH), .req0Valid(req0Valid), .req0Vpn(req0Vpn),
    .req0Write(req0Write), .req0Ready(req0Ready), .resp0Valid(resp0Valid),
    .resp0Ppn(resp0Ppn), .req1Valid(req1Valid), .req1Vpn(req1Vpn),
    .resp1Valid(resp1Valid), .resp1Hit(resp1Hit), .resp1Ppn(resp1Ppn),
    .busy(busy), .refillVpn(refillVpn), .refillBank(refillBank),
    .refillWrite(refillWrite), .refillValid(refillValid), .refillPpn(refillPpn));

  int nChk = 0, nFail = 0;

  function automatic logic [PW-1:0] ppnOf(input logic [VW-1:0] v);
    return (v * 20'd7) ^ 20'h5A5A5;
  endfunction

  function automatic logic [1:0] regionOf(input logic [VW-1:0] v);
    if (v >= SB && v <= SH) return 2'd0;
    if (v >= GB && v <= GH) return 2'd1;
    return 2'd2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive0(input logic [VW-1:0] v, input logic wr);
    @(negedge clk);
    req0Valid = 1'b1; req0Vpn = v; req0Write = wr;
    #1;
  endtask

  task automatic hitAccess(input logic [VW-1:0] v, input string req);
    drive0(v, 1'b0);
    chk(req0Ready == 1'b1, req, "ready", 32'(req0Ready), 1);
    @(posedge clk); #1;
    req0Valid = 1'b0;
    chk(resp0Valid == 1'b1, req, "hit valid", 32'(resp0Valid), 1);
    chk(resp0Ppn == ppnOf(v), req, "hit ppn", 32'(resp0Ppn), 32'(ppnOf(v)));
  endtask

  task automatic finishRefill(input logic [VW-1:0] v, input bit withFlush, input string req);
    repeat (29) @(negedge clk);
    chk(busy == 1'b1, "R3", "busy held", 32'(busy), 1);
    refillValid = 1'b1; refillPpn = ppnOf(v); flush = withFlush;
    @(posedge clk); #1;
    refillValid = 1'b0; flush = 1'b0;
    chk(resp0Valid == 1'b1, req, "completion valid", 32'(resp0Valid), 1);
    chk(resp0Ppn == ppnOf(v), req, "completion ppn", 32'(resp0Ppn), 32'(ppnOf(v)));
    chk(busy == 1'b0, "R4", "busy cleared", 32'(busy), 0);
  endtask

  task automatic missAccess(input logic [VW-1:0] v, input logic wr, input string req);
    drive0(v, wr);
    chk(req0Ready == 1'b1, req, "ready", 32'(req0Ready), 1);
    @(posedge clk); #1;
    req0Valid = 1'b0;
    chk(resp0Valid == 1'b0, req, "no response on miss", 32'(resp0Valid), 0);
    chk(busy == 1'b1, "R3", "busy after miss", 32'(busy), 1);
    chk(refillVpn == v, "R3", "refillVpn", 32'(refillVpn), 32'(v));
    chk(refillBank == regionOf(v), "R1", "refillBank", 32'(refillBank), 32'(regionOf(v)));
    chk(refillWrite == wr, "R3", "refillWrite", 32'(refillWrite), 32'(wr));
    finishRefill(v, 1'b0, "R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [VW-1:0] cls [8];
    rstN = 1'b0; flush = 1'b0; req0Valid = 1'b0; req0Vpn = '0; req0Write = 1'b0;
    req1Valid = 1'b0; req1Vpn = '0; refillValid = 1'b0; refillPpn = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(busy == 1'b0, "R11", "busy", 32'(busy), 0);
    chk(resp0Valid == 1'b0, "R11", "resp0Valid", 32'(resp0Valid), 0);
    chk(resp1Valid == 1'b0, "R11", "resp1Valid", 32'(resp1Valid), 0);
    chk(req0Ready == 1'b1, "R11", "ready", 32'(req0Ready), 1);
    @(negedge clk); rstN = 1'b1;

    // R1 region boundaries, R2 hits afterwards
    cls = '{SB - 1, SB, SH, GB - 1, GB, GH, GH + 1, 20'h00000};
    for (int i = 0; i < 8; i++) missAccess(cls[i], i[0], "R1");
    for (int i = 0; i < 8; i++) hitAccess(cls[i], "R2");

    // R8 stack bank replacement
    hitAccess(SB, "R8");
    missAccess(SB + 1, 1'b0, "R8");
    hitAccess(SB, "R8");
    missAccess(SH, 1'b0, "R8");

    // R9 flush
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
    missAccess(SB, 1'b0, "R9");

    // R8 global pseudo-LRU
    for (int i = 0; i < 8; i++) missAccess(GB + VW'(i), 1'b0, "R8");
    hitAccess(GB, "R8");
    missAccess(GB + 8, 1'b0, "R8");
    for (int i = 0; i < 9; i++) if (i != 4) hitAccess(GB + VW'(i), "R8");
    missAccess(GB + 4, 1'b0, "R8");

    // R7 heap traffic leaves other banks intact
    for (int i = 0; i < 40; i++) missAccess(20'h20000 + VW'(i), 1'b0, "R7");
    hitAccess(SB, "R7");
    hitAccess(GB + 8, "R7");

    // R5 stall rules while a miss is pending
    drive0(20'h30000, 1'b0);
    @(posedge clk); #1; req0Valid = 1'b0;
    chk(busy == 1'b1, "R3", "busy", 32'(busy), 1);
    drive0(20'h20027, 1'b0);
    chk(req0Ready == 1'b0, "R5", "same bank refused", 32'(req0Ready), 0);
    @(posedge clk); #1; req0Valid = 1'b0;
    chk(resp0Valid == 1'b0, "R5", "no response", 32'(resp0Valid), 0);
    drive0(SB, 1'b0);
    chk(req0Ready == 1'b1, "R5", "other bank hit accepted", 32'(req0Ready), 1);
    @(posedge clk); #1; req0Valid = 1'b0;
    chk(resp0Valid == 1'b1 && resp0Ppn == ppnOf(SB), "R5", "hit under miss",
        32'(resp0Ppn), 32'(ppnOf(SB)));
    drive0(GB + 20'h80, 1'b0);
    chk(req0Ready == 1'b0, "R5", "second miss refused", 32'(req0Ready), 0);
    @(posedge clk); #1; req0Valid = 1'b0;
    repeat (26) @(negedge clk);
    refillValid = 1'b1; refillPpn = ppnOf(20'h30000);
    req0Valid = 1'b1; req0Vpn = SB;
    #1;
    chk(req0Ready == 1'b0, "R5", "refill cycle refused", 32'(req0Ready), 0);
    @(posedge clk); #1;
    refillValid = 1'b0; req0Valid = 1'b0;
    chk(resp0Valid == 1'b1 && resp0Ppn == ppnOf(20'h30000), "R4", "completion",
        32'(resp0Ppn), 32'(ppnOf(20'h30000)));
    chk(busy == 1'b0, "R4", "busy cleared", 32'(busy), 0);

    // R6 probe port
    @(negedge clk);
    req0Valid = 1'b1; req0Vpn = SB; req1Valid = 1'b1; req1Vpn = SB;
    @(posedge clk); #1; req0Valid = 1'b0; req1Valid = 1'b0;
    chk(resp0Valid == 1'b1 && resp0Ppn == ppnOf(SB), "R6", "main with probe",
        32'(resp0Ppn), 32'(ppnOf(SB)));
    chk(resp1Valid && resp1Hit && resp1Ppn == ppnOf(SB), "R6", "probe hit",
        32'(resp1Ppn), 32'(ppnOf(SB)));
    @(negedge clk); req1Valid = 1'b1; req1Vpn = 20'h20027;
    @(posedge clk); #1; req1Valid = 1'b0;
    chk(resp1Valid == 1'b0, "R6", "probe heap ignored", 32'(resp1Valid), 0);
    @(negedge clk); req1Valid = 1'b1; req1Vpn = SB + 5;
    @(posedge clk); #1; req1Valid = 1'b0;
    chk(resp1Valid == 1'b1 && resp1Hit == 1'b0, "R6", "probe miss",
        32'({resp1Valid, resp1Hit}), 32'h2);

    // R10 flush and refill together
    drive0(GB + 20'h40, 1'b1);
    @(posedge clk); #1; req0Valid = 1'b0;
    chk(refillWrite == 1'b1, "R3", "store flag", 32'(refillWrite), 1);
    finishRefill(GB + 20'h40, 1'b1, "R10");
    hitAccess(GB + 20'h40, "R10");
    missAccess(SB, 1'b0, "R9");
    missAccess(GB + 8, 1'b0, "R9");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule